// File: doc/BRIEF.md
# AXI Write Burst Throttle

This block sits between an AXI write master that may pause partway through a write burst and a downstream write path that must receive every burst without gaps. Write data beats from the master go into a data buffer. The write address of a burst is held back until every beat of that burst, including the beat marked last, is stored in that buffer. Only then is the address offered downstream. After the downstream side accepts the address, the buffered beats leave on consecutive cycles, so a master that stalls in the middle of a burst can never create holes on the downstream data channel.

Addresses wait in a small address buffer and leave in arrival order. Each address is matched with the oldest complete burst in the data buffer that does not yet have an address. The write response channel connects straight through with no logic. The whole block runs on one clock and has a synchronous active-low reset that empties both buffers and clears all burst bookkeeping.

The data buffer depth must be at least the longest burst in beats. If it is smaller, a maximum-length burst can never be fully stored and its address would never be released. An address buffer depth of zero turns the address buffer into a plain wire-through.

Top module: `wr_burst_throttle`

## Requirements
- R1: After reset, m_aw_valid and m_w_valid are 0, while s_aw_ready and s_w_ready are 1.
- R2: m_aw_valid stays 0 until the beat with s_w_last=1 for the oldest unreleased burst has been accepted into the data buffer. When an address is already waiting, m_aw_valid is 1 from the cycle after that last beat is accepted.
- R3: s_w_ready is 0 exactly when the data buffer holds DATA_DEPTH beats. A beat offered while s_w_ready is 0 is not stored.
- R4: m_w_valid is 0 until the address of the burst has been accepted downstream. From the first beat of a released burst, m_w_valid stays 1 until the beat with m_w_last=1 completes a handshake.
- R5: Beats leave in the order they arrived, with unchanged data, strobe and last flag. While m_w_valid=1 and m_w_ready=0, m_w_data, m_w_strb and m_w_last hold their values.
- R6: Addresses leave in arrival order, each paired with the oldest complete unreleased burst. While m_aw_valid=1 and m_aw_ready=0, m_aw_valid, m_aw_addr, m_aw_len and m_aw_id hold their values.
- R7: The write response channel is combinational: s_b_valid, s_b_id and s_b_resp equal m_b_valid, m_b_id and m_b_resp, and m_b_ready equals s_b_ready, in the same cycle.
- R8: The address buffer holds ADDR_DEPTH entries. s_aw_ready is 0 when it is full.
- R9: Reset discards partially received bursts and queued addresses. The first burst sent after reset leaves with its own address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| s_aw_valid | input | 1 | Upstream address valid |
| s_aw_ready | output | 1 | Upstream address ready |
| s_aw_addr | input | ADDR_W | Upstream burst address |
| s_aw_len | input | 8 | Upstream burst length minus one |
| s_aw_id | input | ID_W | Upstream transaction id |
| s_w_valid | input | 1 | Upstream data valid |
| s_w_ready | output | 1 | Upstream data ready |
| s_w_data | input | DATA_W | Upstream data beat |
| s_w_strb | input | DATA_W/8 | Upstream byte strobes |
| s_w_last | input | 1 | Upstream last beat of burst |
| s_b_valid | output | 1 | Upstream response valid |
| s_b_ready | input | 1 | Upstream response ready |
| s_b_id | output | ID_W | Upstream response id |
| s_b_resp | output | 2 | Upstream response code |
| m_aw_valid | output | 1 | Downstream address valid |
| m_aw_ready | input | 1 | Downstream address ready |
| m_aw_addr | output | ADDR_W | Downstream burst address |
| m_aw_len | output | 8 | Downstream burst length minus one |
| m_aw_id | output | ID_W | Downstream transaction id |
| m_w_valid | output | 1 | Downstream data valid |
| m_w_ready | input | 1 | Downstream data ready |
| m_w_data | output | DATA_W | Downstream data beat |
| m_w_strb | output | DATA_W/8 | Downstream byte strobes |
| m_w_last | output | 1 | Downstream last beat of burst |
| m_b_valid | input | 1 | Downstream response valid |
| m_b_ready | output | 1 | Downstream response ready |
| m_b_id | input | ID_W | Downstream response id |
| m_b_resp | input | 2 | Downstream response code |

## Verification
The address-gating function is driven with four patterns. An address arrives first and its burst pauses for several cycles in the middle. Data arrives before its address. Two addresses are queued ahead of their two bursts. A maximum-length burst fills the data buffer. The first pattern shows whether release waits for the last beat or fires early. The second shows whether the address, not the data, is what holds the release. The third shows whether addresses and bursts pair in order and whether back-to-back bursts drain without a gap. The fourth shows where backpressure starts and checks that an offered beat is refused when the buffer is full. Further patterns cover downstream data backpressure, a full address buffer, reset in the middle of a burst, and the response wire-through.

// File: rtl/wbt_pkg.sv
// Package: shared types and helpers for the write burst throttle.
// Assumes: used only at elaboration time for widths; no state lives here.
package wbt_pkg;

    // AXI burst length field (beats minus one)
    typedef logic [7:0] beats_t;

    // AXI write response code
    typedef logic [1:0] resp_t;

    // Bits needed to count from 0 up to n inclusive
    function automatic int cnt_bits(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Bits needed to index n entries (at least one)
    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wbt_fifo.sv
// Module: wbt_fifo
// A valid/ready first-in first-out buffer of DEPTH entries of WIDTH bits.
// DEPTH = 0 builds a wire-through with no storage.
// Assumes: the writer holds in_data stable while in_valid is high and
// in_ready is low; the head entry stays stable until it is popped.
module wbt_fifo
    import wbt_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);

    generate
        if (DEPTH == 0) begin : g_wire
            // Wire-through variant: no storage, handshake passes straight on
            wire unused_pt = &{1'b0, clk, rst_n};
            assign out_valid = in_valid;
            assign in_ready  = out_ready;
            assign out_data  = in_data;
        end else begin : g_store
            localparam int PW = idx_bits(DEPTH);
            localparam int CW = cnt_bits(DEPTH);
            localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
            localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

            logic [WIDTH-1:0] mem [DEPTH];
            logic [PW-1:0]    wr_ptr;
            logic [PW-1:0]    rd_ptr;
            logic [CW-1:0]    fill;
            logic             push;
            logic             pop;

            assign in_ready  = (fill != FULL_CNT);
            assign out_valid = (fill != '0);
            assign out_data  = mem[rd_ptr];
            assign push      = in_valid && in_ready;
            assign pop       = out_valid && out_ready;

            // Store incoming entries at the write pointer
            always_ff @(posedge clk) begin
                if (push) begin
                    mem[wr_ptr] <= in_data;
                end
            end

            // Advance pointers and occupancy; reset empties the buffer
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wr_ptr <= '0;
                    rd_ptr <= '0;
                    fill   <= '0;
                end else begin
                    if (push) begin
                        wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
                    end
                    if (pop) begin
                        rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
                    end
                    case ({push, pop})
                        2'b10:   fill <= fill + 1'b1;
                        2'b01:   fill <= fill - 1'b1;
                        default: fill <= fill;
                    endcase
                end
            end

            // R3 / R8: occupancy never exceeds the configured depth
            p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
                fill <= FULL_CNT)
                else $error("fifo occupancy above depth");

            // R5: the head entry holds while it waits for the reader
            p_head_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
                else $error("fifo head changed before pop");
        end
    endgenerate

endmodule

// File: rtl/wbt_burst_track.sv
// Module: wbt_burst_track
// Keeps two counts of bursts in the data buffer: complete bursts not yet
// given an address, and bursts whose address has gone downstream but whose
// beats have not all left. The first count gates address release; the
// second gates the downstream data valid.
// Assumes: every burst ends with exactly one beat marked last, and an
// address is released only while aw_allow is high.
module wbt_burst_track
    import wbt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_last,
    input  logic aw_fire,
    input  logic pop_last,
    output logic aw_allow,
    output logic w_allow
);

    localparam int CW = cnt_bits(DEPTH);

    logic [CW-1:0] waiting;
    logic [CW-1:0] granted;

    assign aw_allow = (waiting != '0);
    assign w_allow  = (granted != '0);

    // Complete bursts that still lack a downstream address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting <= '0;
        end else begin
            case ({push_last, aw_fire})
                2'b10:   waiting <= waiting + 1'b1;
                2'b01:   waiting <= waiting - 1'b1;
                default: waiting <= waiting;
            endcase
        end
    end

    // Released bursts whose beats are still draining
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            granted <= '0;
        end else begin
            case ({aw_fire, pop_last})
                2'b10:   granted <= granted + 1'b1;
                2'b01:   granted <= granted - 1'b1;
                default: granted <= granted;
            endcase
        end
    end

    // R2: an address is never released without a complete burst behind it
    p_release_has_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        aw_fire |-> (waiting != '0))
        else $error("address released with no complete burst");

    // R4: a last beat never leaves for a burst that has no address yet
    p_last_was_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_last |-> (granted != '0))
        else $error("last beat left without a released address");

endmodule

// File: rtl/wr_burst_throttle.sv
// Module: wr_burst_throttle
// Holds each write address until its whole data burst is buffered, then
// releases the address and drains the burst downstream without gaps.
// The write response channel is wired straight through.
// Assumes: one clock for both sides; DATA_DEPTH >= MAX_BURST; each
// upstream burst carries exactly one beat with s_w_last set.
module wr_burst_throttle
    import wbt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 4,
    parameter int DATA_W     = 32,
    parameter int MAX_BURST  = 16,
    parameter int DATA_DEPTH = 16,
    parameter int ADDR_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_aw_valid,
    output logic              s_aw_ready,
    input  logic [ADDR_W-1:0] s_aw_addr,
    input  logic [7:0]        s_aw_len,
    input  logic [ID_W-1:0]   s_aw_id,
    input  logic              s_w_valid,
    output logic              s_w_ready,
    input  logic [DATA_W-1:0] s_w_data,
    input  logic [DATA_W/8-1:0] s_w_strb,
    input  logic              s_w_last,
    output logic              s_b_valid,
    input  logic              s_b_ready,
    output logic [ID_W-1:0]   s_b_id,
    output logic [1:0]        s_b_resp,
    output logic              m_aw_valid,
    input  logic              m_aw_ready,
    output logic [ADDR_W-1:0] m_aw_addr,
    output logic [7:0]        m_aw_len,
    output logic [ID_W-1:0]   m_aw_id,
    output logic              m_w_valid,
    input  logic              m_w_ready,
    output logic [DATA_W-1:0] m_w_data,
    output logic [DATA_W/8-1:0] m_w_strb,
    output logic              m_w_last,
    input  logic              m_b_valid,
    output logic              m_b_ready,
    input  logic [ID_W-1:0]   m_b_id,
    input  logic [1:0]        m_b_resp
);

    localparam int STRB_W = DATA_W / 8;
    localparam int AWW    = ID_W + $bits(beats_t) + ADDR_W;
    localparam int WW     = STRB_W + 1 + DATA_W;

    // Elaboration sanity: a maximum burst must fit in the data buffer
    initial begin
        assert (DATA_DEPTH >= MAX_BURST && DATA_DEPTH > 0)
            else $error("DATA_DEPTH must be at least MAX_BURST");
    end

    logic [AWW-1:0] aw_in_pack;
    logic [AWW-1:0] aw_out_pack;
    logic           aw_head_valid;
    logic           aw_head_take;
    logic [WW-1:0]  w_in_pack;
    logic [WW-1:0]  w_out_pack;
    logic           w_head_valid;
    logic           w_head_take;
    logic           aw_allow;
    logic           w_allow;
    logic           push_last;
    logic           pop_last;
    logic           aw_fire;

    // Pack address and data payloads for the buffers
    assign aw_in_pack = {s_aw_id, beats_t'(s_aw_len), s_aw_addr};
    assign w_in_pack  = {s_w_strb, s_w_last, s_w_data};

    wbt_fifo #(
        .WIDTH (AWW),
        .DEPTH (ADDR_DEPTH)
    ) u_aw_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_aw_valid),
        .in_ready  (s_aw_ready),
        .in_data   (aw_in_pack),
        .out_valid (aw_head_valid),
        .out_ready (aw_head_take),
        .out_data  (aw_out_pack)
    );

    wbt_fifo #(
        .WIDTH (WW),
        .DEPTH (DATA_DEPTH)
    ) u_w_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_w_valid),
        .in_ready  (s_w_ready),
        .in_data   (w_in_pack),
        .out_valid (w_head_valid),
        .out_ready (w_head_take),
        .out_data  (w_out_pack)
    );

    // Burst boundary events seen by the tracker
    assign push_last = s_w_valid && s_w_ready && s_w_last;
    assign aw_fire   = m_aw_valid && m_aw_ready;
    assign pop_last  = m_w_valid && m_w_ready && m_w_last;

    wbt_burst_track #(
        .DEPTH (DATA_DEPTH)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_last (push_last),
        .aw_fire   (aw_fire),
        .pop_last  (pop_last),
        .aw_allow  (aw_allow),
        .w_allow   (w_allow)
    );

    // Downstream address: offered only with a complete burst waiting
    assign m_aw_valid   = aw_head_valid && aw_allow;
    assign aw_head_take = m_aw_ready && aw_allow;
    assign {m_aw_id, m_aw_len, m_aw_addr} = aw_out_pack;

    // Downstream data: offered only for bursts whose address has gone
    assign m_w_valid   = w_head_valid && w_allow;
    assign w_head_take = m_w_ready && w_allow;
    assign {m_w_strb, m_w_last, m_w_data} = w_out_pack;

    // Response channel wire-through
    assign s_b_valid = m_b_valid;
    assign s_b_id    = m_b_id;
    assign s_b_resp  = m_b_resp;
    assign m_b_ready = s_b_ready;

    // R4: once offered, downstream data valid holds until taken
    p_w_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_w_valid && !m_w_ready) |=> m_w_valid)
        else $error("downstream data valid dropped before handshake");

    // R4: a burst that has started draining has its next beat ready at once
    p_w_gapless_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_w_valid && m_w_ready && !m_w_last) |=> m_w_valid)
        else $error("gap inside a downstream burst");

    // R5: the beat and its last flag hold while waiting
    p_w_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_w_valid && !m_w_ready) |=>
            ($stable(m_w_data) && $stable(m_w_strb) && $stable(m_w_last)))
        else $error("downstream beat changed before handshake");

    // R6: a released address holds until accepted
    p_aw_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_aw_valid && !m_aw_ready) |=>
            (m_aw_valid && $stable(m_aw_addr) && $stable(m_aw_len) && $stable(m_aw_id)))
        else $error("downstream address changed before handshake");

endmodule

// File: tb/tb_wr_burst_throttle.sv
// Directed bench for wr_burst_throttle. Inputs are driven and outputs are
// sampled at the falling edge; every scenario task checks its own results.
module tb_wr_burst_throttle;

    localparam int ADDR_W = 32;
    localparam int ID_W   = 4;
    localparam int DATA_W = 32;
    localparam int DDEPTH = 16;
    localparam int ADEPTH = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              s_aw_valid, s_aw_ready;
    logic [ADDR_W-1:0] s_aw_addr;
    logic [7:0]        s_aw_len;
    logic [ID_W-1:0]   s_aw_id;
    logic              s_w_valid, s_w_ready;
    logic [DATA_W-1:0] s_w_data;
    logic [3:0]        s_w_strb;
    logic              s_w_last;
    logic              s_b_valid, s_b_ready;
    logic [ID_W-1:0]   s_b_id;
    logic [1:0]        s_b_resp;
    logic              m_aw_valid, m_aw_ready;
    logic [ADDR_W-1:0] m_aw_addr;
    logic [7:0]        m_aw_len;
    logic [ID_W-1:0]   m_aw_id;
    logic              m_w_valid, m_w_ready;
    logic [DATA_W-1:0] m_w_data;
    logic [3:0]        m_w_strb;
    logic              m_w_last;
    logic              m_b_valid, m_b_ready;
    logic [ID_W-1:0]   m_b_id;
    logic [1:0]        m_b_resp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    wr_burst_throttle #(
        .ADDR_W     (ADDR_W),
        .ID_W       (ID_W),
        .DATA_W     (DATA_W),
        .MAX_BURST  (16),
        .DATA_DEPTH (DDEPTH),
        .ADDR_DEPTH (ADEPTH)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .s_aw_valid (s_aw_valid), .s_aw_ready (s_aw_ready), .s_aw_addr (s_aw_addr),
        .s_aw_len (s_aw_len), .s_aw_id (s_aw_id),
        .s_w_valid (s_w_valid), .s_w_ready (s_w_ready), .s_w_data (s_w_data),
        .s_w_strb (s_w_strb), .s_w_last (s_w_last),
        .s_b_valid (s_b_valid), .s_b_ready (s_b_ready), .s_b_id (s_b_id), .s_b_resp (s_b_resp),
        .m_aw_valid (m_aw_valid), .m_aw_ready (m_aw_ready), .m_aw_addr (m_aw_addr),
        .m_aw_len (m_aw_len), .m_aw_id (m_aw_id),
        .m_w_valid (m_w_valid), .m_w_ready (m_w_ready), .m_w_data (m_w_data),
        .m_w_strb (m_w_strb), .m_w_last (m_w_last),
        .m_b_valid (m_b_valid), .m_b_ready (m_b_ready), .m_b_id (m_b_id), .m_b_resp (m_b_resp)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic send_aw(input logic [ADDR_W-1:0] addr, input logic [7:0] len);
        s_aw_valid = 1'b1;
        s_aw_addr  = addr;
        s_aw_len   = len;
        s_aw_id    = addr[15:12];
        tick();
        s_aw_valid = 1'b0;
    endtask

    // Beats first..first+count-1 of a burst of total beats, back to back
    task automatic send_beats(input logic [DATA_W-1:0] base, input int first,
                              input int count, input int total);
        for (int i = first; i < first + count; i++) begin
            s_w_valid = 1'b1;
            s_w_data  = base + DATA_W'(i);
            s_w_strb  = 4'(i + 1);
            s_w_last  = (i == total - 1);
            tick();
        end
        s_w_valid = 1'b0;
        s_w_last  = 1'b0;
    endtask

    // Expect n consecutive beats with m_w_ready held high
    task automatic drain(input logic [DATA_W-1:0] base, input int n, input string req);
        m_w_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            check(req, "drain valid", 64'(m_w_valid), 64'd1);
            check(req, "drain data", 64'(m_w_data), 64'(base + DATA_W'(i)));
            check(req, "drain last", 64'(m_w_last), 64'(i == n - 1));
            tick();
        end
    endtask

    task automatic accept_aw();
        m_aw_ready = 1'b1;
        tick();
        m_aw_ready = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1", "m_aw_valid", 64'(m_aw_valid), 64'd0);
        check("R1", "m_w_valid", 64'(m_w_valid), 64'd0);
        check("R1", "s_aw_ready", 64'(s_aw_ready), 64'd1);
        check("R1", "s_w_ready", 64'(s_w_ready), 64'd1);
    endtask

    // Address first, burst pauses in the middle (R2, R4, R5, R6)
    task automatic t_stalled_burst();
        send_aw(32'h0000_1000, 8'd3);
        send_beats(32'hA000_0000, 0, 2, 4);
        for (int k = 0; k < 3; k++) begin
            check("R2", "aw held during pause", 64'(m_aw_valid), 64'd0);
            check("R4", "no data during pause", 64'(m_w_valid), 64'd0);
            tick();
        end
        send_beats(32'hA000_0000, 2, 2, 4);
        check("R2", "aw after last beat", 64'(m_aw_valid), 64'd1);
        check("R6", "aw addr", 64'(m_aw_addr), 64'h1000);
        tick();
        check("R6", "aw still valid", 64'(m_aw_valid), 64'd1);
        check("R6", "aw len held", 64'(m_aw_len), 64'd3);
        check("R4", "no data before aw", 64'(m_w_valid), 64'd0);
        accept_aw();
        drain(32'hA000_0000, 4, "R4");
        m_w_ready = 1'b0;
        check("R4", "idle after burst", 64'(m_w_valid), 64'd0);
    endtask

    // Downstream data backpressure (R5)
    task automatic t_w_backpressure();
        send_aw(32'h0000_2000, 8'd2);
        send_beats(32'hB000_0000, 0, 3, 3);
        accept_aw();
        check("R5", "head data", 64'(m_w_data), 64'hB000_0000);
        check("R5", "head strb", 64'(m_w_strb), 64'd1);
        tick();
        check("R5", "held valid", 64'(m_w_valid), 64'd1);
        check("R5", "held data", 64'(m_w_data), 64'hB000_0000);
        m_w_ready = 1'b1;
        tick();
        m_w_ready = 1'b0;
        check("R5", "second data", 64'(m_w_data), 64'hB000_0001);
        tick();
        check("R5", "second held", 64'(m_w_data), 64'hB000_0001);
        check("R5", "second strb", 64'(m_w_strb), 64'd2);
        drain(32'hB000_0001, 2, "R5");
        m_w_ready = 1'b0;
    endtask

    // Data before address (R2, R4)
    task automatic t_data_first();
        send_beats(32'hC000_0000, 0, 2, 2);
        tick();
        check("R2", "no aw yet", 64'(m_aw_valid), 64'd0);
        check("R4", "no data without aw", 64'(m_w_valid), 64'd0);
        send_aw(32'h0000_3000, 8'd1);
        check("R2", "aw once present", 64'(m_aw_valid), 64'd1);
        check("R2", "aw addr", 64'(m_aw_addr), 64'h3000);
        accept_aw();
        drain(32'hC000_0000, 2, "R4");
        m_w_ready = 1'b0;
    endtask

    // Two addresses queued ahead of two bursts (R6)
    task automatic t_order();
        send_aw(32'h0000_4000, 8'd1);
        send_aw(32'h0000_5000, 8'd0);
        send_beats(32'hD000_0000, 0, 2, 2);
        send_beats(32'hE000_0000, 0, 1, 1);
        check("R6", "first aw", 64'(m_aw_addr), 64'h4000);
        check("R6", "first id", 64'(m_aw_id), 64'd4);
        m_aw_ready = 1'b1;
        tick();
        check("R6", "second aw valid", 64'(m_aw_valid), 64'd1);
        check("R6", "second aw", 64'(m_aw_addr), 64'h5000);
        tick();
        m_aw_ready = 1'b0;
        check("R6", "no third aw", 64'(m_aw_valid), 64'd0);
        drain(32'hD000_0000, 2, "R6");
        drain(32'hE000_0000, 1, "R6");
        m_w_ready = 1'b0;
        check("R6", "all drained", 64'(m_w_valid), 64'd0);
    endtask

    // Fill the data buffer with a maximum burst (R3)
    task automatic t_fill();
        send_aw(32'h0000_6000, 8'd15);
        send_beats(32'hF000_0000, 0, 15, 16);
        check("R3", "ready one below full", 64'(s_w_ready), 64'd1);
        send_beats(32'hF000_0000, 15, 1, 16);
        check("R3", "not ready when full", 64'(s_w_ready), 64'd0);
        s_w_valid = 1'b1;
        s_w_data  = 32'hDEAD_BEEF;
        s_w_last  = 1'b1;
        tick();
        tick();
        check("R3", "still full", 64'(s_w_ready), 64'd0);
        s_w_valid = 1'b0;
        s_w_last  = 1'b0;
        accept_aw();
        drain(32'hF000_0000, 16, "R3");
        m_w_ready = 1'b0;
        check("R3", "refused beat not stored", 64'(m_w_valid), 64'd0);
        check("R3", "no extra aw", 64'(m_aw_valid), 64'd0);
    endtask

    // Address buffer full (R8)
    task automatic t_aw_full();
        for (int i = 0; i < ADEPTH; i++) begin
            send_aw(32'h0000_7000 + 32'(i * 16), 8'd0);
        end
        check("R8", "aw buffer full", 64'(s_aw_ready), 64'd0);
        check("R2", "no data so no release", 64'(m_aw_valid), 64'd0);
    endtask

    // Reset with queued addresses and a partial burst (R9, R1)
    task automatic t_reset_clear();
        send_beats(32'h9000_0000, 0, 1, 3);
        do_reset();
        check("R9", "aw ready after reset", 64'(s_aw_ready), 64'd1);
        check("R9", "w ready after reset", 64'(s_w_ready), 64'd1);
        check("R1", "aw valid after reset", 64'(m_aw_valid), 64'd0);
        check("R1", "w valid after reset", 64'(m_w_valid), 64'd0);
        send_aw(32'h0000_8000, 8'd0);
        send_beats(32'h8800_0000, 0, 1, 1);
        check("R9", "fresh aw valid", 64'(m_aw_valid), 64'd1);
        check("R9", "fresh aw addr", 64'(m_aw_addr), 64'h8000);
        accept_aw();
        drain(32'h8800_0000, 1, "R9");
        m_w_ready = 1'b0;
        check("R9", "nothing stale", 64'(m_w_valid), 64'd0);
    endtask

    // Response wire-through (R7)
    task automatic t_resp();
        m_b_valid = 1'b1;
        m_b_id    = 4'd5;
        m_b_resp  = 2'd2;
        s_b_ready = 1'b0;
        #1;
        check("R7", "b valid", 64'(s_b_valid), 64'd1);
        check("R7", "b id", 64'(s_b_id), 64'd5);
        check("R7", "b resp", 64'(s_b_resp), 64'd2);
        check("R7", "b ready low", 64'(m_b_ready), 64'd0);
        s_b_ready = 1'b1;
        #1;
        check("R7", "b ready high", 64'(m_b_ready), 64'd1);
        m_b_valid = 1'b0;
        #1;
        check("R7", "b valid low", 64'(s_b_valid), 64'd0);
        tick();
    endtask

    initial begin
        rst_n = 1'b0;
        s_aw_valid = 1'b0; s_aw_addr = '0; s_aw_len = '0; s_aw_id = '0;
        s_w_valid = 1'b0; s_w_data = '0; s_w_strb = '0; s_w_last = 1'b0;
        s_b_ready = 1'b0;
        m_aw_ready = 1'b0; m_w_ready = 1'b0;
        m_b_valid = 1'b0; m_b_id = '0; m_b_resp = '0;
        tick();
        do_reset();
        t_reset_state();
        t_stalled_burst();
        t_w_backpressure();
        t_data_first();
        t_order();
        t_fill();
        t_aw_full();
        t_reset_clear();
        t_resp();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule